// File: doc/BRIEF.md
# Padded Vertex Count Calculator

This unit turns an actual vertex count into a padded count that a thread dispatcher can split into a vertex index and an instance index with little logic. Each padded value has the form odd·2^shift, where the odd factor is 1, 3, 5, 7 or 9. A divide or modulo by such a value is a shift plus a small constant divide. The padded count is always larger than the input and always a multiple of four. Beside the padded count, the unit gives its decomposition: an odd code m, where odd = 2m+1, and the shift.

For counts of 32 and above, the unit finds the leading one of the count and reads it together with the three bits below it. Call that four-bit window h, which lies from 8 to 15, and let n be the number of bits under the window. The result is the next allowed multiplier above h, times 2^n. For counts below 32 the window rule can give values that are not multiples of four. A small path therefore rounds up to the next multiple of four instead, and every such value in this range already has the allowed form.

A request is presented with `in_valid`. Results are registered and appear with `out_valid` one clock later. The registered result holds while no request is presented.

Top module: `pvc_pad_calc`

## Requirements
- R1: While `rst` is high and on the first cycle after it, `out_valid`, `out_padded`, `out_odd_code` and `out_shift` are all zero.
- R2: `out_valid` is high in the cycle after a clock edge at which `in_valid` was high, and low in the cycle after an edge at which it was low.
- R3: Every reported padded count is strictly greater than the count it was computed from.
- R4: Every reported padded count is a multiple of four (bits 1:0 are zero).
- R5: The reported count equals (2·`out_odd_code`+1) shifted left by `out_shift`, and `out_odd_code` is at most 4 (odd factor 1, 3, 5, 7 or 9).
- R6: For a count below 32, the padded count is the count with bits 1:0 cleared plus 4. A count of 0 therefore gives 4, and 31 gives 32.
- R7: For a count of 32 or more, take h as the leading one and the three bits below it, and n = (leading one position) − 3. The padded count is k·2^n, with k = 9 for h=8, k = 10 for h=9, k = 12 for h=10 or 11, k = 14 for h=12 or 13, and k = 16 for h=14 or 15. For example, 70 gives 72, with odd code 4 and shift 3.
- R8: When the odd factor is 1 (the padded count is a power of two), `out_odd_code` is 0. The largest 32-bit count, 2^32−1, gives 2^32 with odd code 0 and shift 32. This needs a 33-bit padded output and a 6-bit shift.
- R9: In a cycle with `in_valid` low, `out_padded`, `out_odd_code` and `out_shift` keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | A count is presented this cycle |
| in_count | input | CNT_W (32) | Actual vertex count |
| out_valid | output | 1 | Result registered from the previous cycle's request |
| out_padded | output | CNT_W+1 (33) | Padded count |
| out_odd_code | output | 3 | m, where the odd factor is 2m+1 |
| out_shift | output | $clog2(CNT_W+1) (6) | Power-of-two exponent of the padded count |

## Verification
Every result is due exactly one clock after its request. The bench drives a request on a falling edge and compares all four outputs on the next falling edge, after the single register stage has updated. Cycles with `in_valid` low are compared on that same cycle against the previously expected values, which checks both the hold behaviour and the low `out_valid`. The expected padded count comes from an exhaustive search for the smallest multiple of four above the input whose odd part is 1, 3, 5, 7 or 9. That search is independent of the window rule the design uses.

// File: rtl/pvc_pkg.sv
package pvc_pkg;
  // Width of the odd-factor code m (odd = 2m+1, m in 0..4)
  localparam int ODD_CODE_W = 3;
  // Width of the multiplier k applied to 2^n on the window path
  localparam int MULT_W = 5;
  // Leading-one position from which the window path takes over
  localparam int WINDOW_MIN_POS = 5;

  typedef enum logic [2:0] {
    MUL_9  = 3'd0,
    MUL_10 = 3'd1,
    MUL_12 = 3'd2,
    MUL_14 = 3'd3,
    MUL_16 = 3'd4
  } mult_sel_e;
endpackage

// File: rtl/pvc_msb_window.sv
module pvc_msb_window #(
  parameter int CNT_W = 32,
  parameter int POS_W = $clog2(CNT_W)
) (
  input  logic [CNT_W-1:0] count_i,
  output logic [POS_W-1:0] lead_pos_o,
  output logic [3:0]       lead_nib_o,
  output logic             wide_o
);
  import pvc_pkg::*;

  logic [CNT_W-1:0] aligned;

  always_comb begin
    lead_pos_o = '0;
    for (int b = 0; b < CNT_W; b++) begin
      if (count_i[b]) lead_pos_o = POS_W'(b);
    end
  end

  always_comb begin
    if (lead_pos_o >= POS_W'(3)) aligned = count_i >> (lead_pos_o - POS_W'(3));
    else                         aligned = count_i;
    lead_nib_o = aligned[3:0];
    wide_o     = (lead_pos_o >= POS_W'(WINDOW_MIN_POS));
  end
endmodule

// File: rtl/pvc_large_step.sv
module pvc_large_step #(
  parameter int POS_W   = 5,
  parameter int SHIFT_W = 6
) (
  input  logic [3:0]                       lead_nib_i,
  input  logic [POS_W-1:0]                 lead_pos_i,
  output logic [pvc_pkg::MULT_W-1:0]       mult_o,
  output logic [pvc_pkg::ODD_CODE_W-1:0]   odd_code_o,
  output logic [SHIFT_W-1:0]               shift_o,
  output logic [SHIFT_W-1:0]               base_o
);
  import pvc_pkg::*;

  mult_sel_e           sel;
  logic [SHIFT_W-1:0]  extra;

  always_comb begin
    unique case (lead_nib_i)
      4'd8:          sel = MUL_9;
      4'd9:          sel = MUL_10;
      4'd10, 4'd11:  sel = MUL_12;
      4'd12, 4'd13:  sel = MUL_14;
      default:       sel = MUL_16;
    endcase
  end

  always_comb begin
    unique case (sel)
      MUL_9:   begin mult_o = 5'd9;  odd_code_o = 3'd4; extra = SHIFT_W'(0); end
      MUL_10:  begin mult_o = 5'd10; odd_code_o = 3'd2; extra = SHIFT_W'(1); end
      MUL_12:  begin mult_o = 5'd12; odd_code_o = 3'd1; extra = SHIFT_W'(2); end
      MUL_14:  begin mult_o = 5'd14; odd_code_o = 3'd3; extra = SHIFT_W'(1); end
      default: begin mult_o = 5'd16; odd_code_o = 3'd0; extra = SHIFT_W'(4); end
    endcase
    base_o  = SHIFT_W'(lead_pos_i) - SHIFT_W'(3);
    shift_o = base_o + extra;
  end
endmodule

// File: rtl/pvc_small_step.sv
module pvc_small_step #(
  parameter int PAD_W   = 33,
  parameter int SHIFT_W = 6
) (
  input  logic [2:0]                     quad_i,
  output logic [PAD_W-1:0]               padded_o,
  output logic [pvc_pkg::ODD_CODE_W-1:0] odd_code_o,
  output logic [SHIFT_W-1:0]             shift_o
);
  logic [3:0] quads;

  always_comb begin
    quads    = {1'b0, quad_i} + 4'd1;
    padded_o = PAD_W'({quads, 2'b00});
    unique case (quads)
      4'd1:    begin odd_code_o = 3'd0; shift_o = SHIFT_W'(2); end
      4'd2:    begin odd_code_o = 3'd0; shift_o = SHIFT_W'(3); end
      4'd3:    begin odd_code_o = 3'd1; shift_o = SHIFT_W'(2); end
      4'd4:    begin odd_code_o = 3'd0; shift_o = SHIFT_W'(4); end
      4'd5:    begin odd_code_o = 3'd2; shift_o = SHIFT_W'(2); end
      4'd6:    begin odd_code_o = 3'd1; shift_o = SHIFT_W'(3); end
      4'd7:    begin odd_code_o = 3'd3; shift_o = SHIFT_W'(2); end
      default: begin odd_code_o = 3'd0; shift_o = SHIFT_W'(5); end
    endcase
  end
endmodule

// File: rtl/pvc_pad_calc.sv
module pvc_pad_calc #(
  parameter int CNT_W = 32,
  parameter int PAD_W = CNT_W + 1,
  parameter int POS_W = $clog2(CNT_W),
  parameter int SHIFT_W = $clog2(CNT_W + 1)
) (
  input  logic                                  clk,
  input  logic                                  rst,
  input  logic                                  in_valid,
  input  logic [CNT_W-1:0]                      in_count,
  output logic                                  out_valid,
  output logic [PAD_W-1:0]                      out_padded,
  output logic [pvc_pkg::ODD_CODE_W-1:0]        out_odd_code,
  output logic [SHIFT_W-1:0]                    out_shift
);
  import pvc_pkg::*;

  logic [POS_W-1:0]      lead_pos;
  logic [3:0]            lead_nib;
  logic                  wide;
  logic [MULT_W-1:0]     big_mult;
  logic [ODD_CODE_W-1:0] big_code, small_code;
  logic [SHIFT_W-1:0]    big_shift, big_base, small_shift;
  logic [PAD_W-1:0]      big_pad, small_pad;
  logic [PAD_W-1:0]      nxt_pad;
  logic [ODD_CODE_W-1:0] nxt_code;
  logic [SHIFT_W-1:0]    nxt_shift;

  pvc_msb_window #(.CNT_W(CNT_W), .POS_W(POS_W)) win_i (
    .count_i    (in_count),
    .lead_pos_o (lead_pos),
    .lead_nib_o (lead_nib),
    .wide_o     (wide)
  );

  pvc_large_step #(.POS_W(POS_W), .SHIFT_W(SHIFT_W)) big_i (
    .lead_nib_i (lead_nib),
    .lead_pos_i (lead_pos),
    .mult_o     (big_mult),
    .odd_code_o (big_code),
    .shift_o    (big_shift),
    .base_o     (big_base)
  );

  pvc_small_step #(.PAD_W(PAD_W), .SHIFT_W(SHIFT_W)) small_i (
    .quad_i     (in_count[4:2]),
    .padded_o   (small_pad),
    .odd_code_o (small_code),
    .shift_o    (small_shift)
  );

  assign big_pad = PAD_W'(big_mult) << big_base;

  always_comb begin
    if (wide) begin
      nxt_pad   = big_pad;
      nxt_code  = big_code;
      nxt_shift = big_shift;
    end else begin
      nxt_pad   = small_pad;
      nxt_code  = small_code;
      nxt_shift = small_shift;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid    <= 1'b0;
      out_padded   <= '0;
      out_odd_code <= '0;
      out_shift    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        out_padded   <= nxt_pad;
        out_odd_code <= nxt_code;
        out_shift    <= nxt_shift;
      end
    end
  end
endmodule

// File: rtl/pvc_pad_calc_chk.sv
module pvc_pad_calc_chk #(
  parameter int CNT_W = 32,
  parameter int PAD_W = CNT_W + 1,
  parameter int SHIFT_W = $clog2(CNT_W + 1)
) (
  input logic               clk,
  input logic               rst,
  input logic               in_valid,
  input logic [CNT_W-1:0]   in_count,
  input logic               out_valid,
  input logic [PAD_W-1:0]   out_padded,
  input logic [2:0]         out_odd_code,
  input logic [SHIFT_W-1:0] out_shift
);
  AST_RESET_CLEARS: assert property (@(posedge clk) rst |=> (!out_valid && out_padded == '0)); // R1
  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (rst) (in_valid |=> out_valid)); // R2
  AST_VALID_DROPS: assert property (@(posedge clk) disable iff (rst) (!in_valid |=> !out_valid)); // R2
  AST_PAD_ABOVE: assert property (@(posedge clk) disable iff (rst) (in_valid |=> out_padded > {1'b0, $past(in_count)})); // R3
  AST_PAD_MUL4: assert property (@(posedge clk) disable iff (rst) (out_valid |-> out_padded[1:0] == 2'b00)); // R4
  AST_PAD_FORM: assert property (@(posedge clk) disable iff (rst) (out_valid |-> (out_odd_code <= 3'd4 && out_padded == (PAD_W'({out_odd_code, 1'b1}) << out_shift)))); // R5
  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (rst) (!in_valid |=> ($stable(out_padded) && $stable(out_shift) && $stable(out_odd_code)))); // R9
endmodule

bind pvc_pad_calc pvc_pad_calc_chk #(.CNT_W(CNT_W), .PAD_W(PAD_W), .SHIFT_W(SHIFT_W)) chk_i (.*);

// File: tb/pvc_pad_calc_tb_top.sv
`timescale 1ns/1ps
module pvc_pad_calc_tb_top;
  localparam int CNT_W = 32;
  localparam int PAD_W = CNT_W + 1;
  localparam int SHIFT_W = $clog2(CNT_W + 1);

  logic               clk = 1'b0;
  logic               rst = 1'b1;
  logic               in_valid = 1'b0;
  logic [CNT_W-1:0]   in_count = '0;
  logic               out_valid;
  logic [PAD_W-1:0]   out_padded;
  logic [2:0]         out_odd_code;
  logic [SHIFT_W-1:0] out_shift;

  int checks = 0;
  int errors = 0;
  longint exp_pad = 0;
  longint exp_m = 0;
  longint exp_s = 0;

  always #2.5 clk = ~clk;

  pvc_pad_calc #(.CNT_W(CNT_W)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_count(in_count),
    .out_valid(out_valid), .out_padded(out_padded),
    .out_odd_code(out_odd_code), .out_shift(out_shift)
  );

  task automatic check(input string tag, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  // Smallest multiple of four above x whose odd part is 1,3,5,7 or 9
  task automatic model(input longint x, output longint pad, output longint m, output longint s);
    int odds[5] = '{1, 3, 5, 7, 9};
    pad = 64'h7fff_ffff_ffff_ffff;
    m = 0;
    s = 0;
    for (int sh = 0; sh < 40; sh++) begin
      for (int k = 0; k < 5; k++) begin
        longint v = longint'(odds[k]) << sh;
        if (v > x && (v % 4) == 0 && v < pad) begin
          pad = v;
        end
      end
    end
    begin
      longint t = pad;
      while ((t % 2) == 0) begin
        t = t / 2;
        s++;
      end
      m = (t - 1) / 2;
    end
  endtask

  task automatic send(input longint x);
    @(negedge clk);
    in_valid = 1'b1;
    in_count = CNT_W'(x);
    model(x, exp_pad, exp_m, exp_s);
    @(negedge clk);
    check("R2 out_valid", longint'(out_valid), 1);
    if (x < 32) check("R6 small padded", longint'(out_padded), exp_pad);
    else        check("R7 window padded", longint'(out_padded), exp_pad);
    check("R3 above input", longint'(out_padded > PAD_W'(x)), 1);
    check("R4 multiple of four", longint'(out_padded[1:0]), 0);
    check("R5 odd code", longint'(out_odd_code), exp_m);
    check("R5 shift", longint'(out_shift), exp_s);
    in_valid = 1'b0;
  endtask

  task automatic idle(input longint x);
    @(negedge clk);
    in_valid = 1'b0;
    in_count = CNT_W'(x);
    @(negedge clk);
    check("R2 out_valid low", longint'(out_valid), 0);
    check("R9 hold padded", longint'(out_padded), exp_pad);
    check("R9 hold code", longint'(out_odd_code), exp_m);
    check("R9 hold shift", longint'(out_shift), exp_s);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset valid", longint'(out_valid), 0);
    check("R1 reset padded", longint'(out_padded), 0);
    check("R1 reset code", longint'(out_odd_code), 0);
    check("R1 reset shift", longint'(out_shift), 0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 after reset valid", longint'(out_valid), 0);

    send(0);
    check("R6 zero gives 4", longint'(out_padded), 4);
    send(1); send(3); send(4); send(7); send(8); send(15); send(16); send(27);
    send(31);
    check("R8 31 gives odd code 0", longint'(out_odd_code), 0);
    check("R8 31 gives shift 5", longint'(out_shift), 5);
    send(32); send(33); send(63); send(64);
    send(70);
    check("R7 70 padded", longint'(out_padded), 72);
    check("R7 70 code", longint'(out_odd_code), 4);
    check("R7 70 shift", longint'(out_shift), 3);
    idle(12345);
    send(71); send(72); send(100); send(255); send(1000);
    idle(5);
    send(64'h8000_0000); send(64'hE000_0000); send(64'hF000_0000);
    send(64'hFFFF_FFFF);
    check("R8 max padded", longint'(out_padded), 64'h1_0000_0000);
    check("R8 max code", longint'(out_odd_code), 0);
    check("R8 max shift", longint'(out_shift), 32);
    for (int i = 0; i < 300; i++) begin
      longint x = longint'($urandom) >> ($urandom % 32);
      send(x);
      if ((i % 17) == 0) idle(longint'($urandom));
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule